// File: doc/BRIEF.md
# Scaled Window Source Address Generator

This block walks a display window's source rectangle while the output raster runs at a different size. It keeps two fixed-point accumulators, one per axis, each with 12 fraction bits. The integer part of each accumulator picks the source column or row. Software programs each increment as the ratio of source size to output size, using the formula `src * 4096 / max(out - 1, 1)`. For every raster event it produces a source x, a source y and a frame-buffer byte address. A pixel fetcher downstream consumes these.

Raster events come in on a valid/ready command stream, one of four operations per beat: step one output pixel, start a line, start a frame, or repeat. Each accepted command yields exactly one beat on the valid/ready result stream. A command is accepted only while the result slot is empty or is being drained in the same cycle. If the result consumer holds ready low, the back-pressure therefore reaches the raster source within the same cycle.

The configuration pins are live values. They are copied into an internal working set only at a frame command, and only once a commit request has been seen. Changes made in the middle of a frame therefore never tear the image.

Top module: `win_scale_addr_gen`

## Requirements
- R1: `cmd_ready` equals `!pix_valid || pix_ready`. Every accepted command raises `pix_valid` in the next cycle. `pix_valid` falls one cycle after a beat is consumed if no new command was accepted in that cycle.
- R2: While `pix_valid` is high and `pix_ready` is low, `pix_x`, `pix_y` and `pix_addr` hold their values and no command is accepted.
- R3: `cmd_op` encoding: 0 steps one output pixel, 1 starts a line, 2 starts a frame, 3 repeats the current beat and leaves all state unchanged.
- R4: The horizontal accumulator reloads the working horizontal start value on a frame or line command. A step command adds the horizontal increment to it. Bits above the 12 fraction bits give the source column before clamping.
- R5: The vertical accumulator reloads the working vertical start value on a frame command. The first line command after a frame, or after reset, leaves it unchanged. Every later line command adds the vertical increment.
- R6: The source column is clamped to `width_px - 1`, where `width_px = cfg_src_bytes >> s` and s is 1 for 16 bpp or 2 for 32 bpp. The source row is clamped to `cfg_src_lines - 1`. A size of zero gives coordinate 0.
- R7: When an addition would exceed the accumulator width of 28 bits, the accumulator stops at all ones instead of wrapping.
- R8: `pix_addr = base + xoff + (x << s) + (yoff + y) * pitch`, computed modulo 2^32. Here xoff is in bytes, yoff is in lines and pitch is in bytes per line.
- R9: `cfg_fmt` 0 selects 16 bpp (2 bytes per pixel, `color_expand` = 1). `cfg_fmt` 1 selects 32 bpp (4 bytes per pixel, `color_expand` = 0).
- R10: The live configuration replaces the working set only when a frame command is accepted after a `cfg_commit` pulse, or together with one in the same cycle. Otherwise every output keeps using the old working set. A frame command that applies a new set reloads the accumulators from the new start values.
- R11: After reset `pix_valid` is 0, `cmd_ready` is 1, and the working set and both accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Window buffer start byte address |
| cfg_xoff | input | COORD_W | Horizontal source offset in bytes |
| cfg_yoff | input | COORD_W | Vertical source offset in lines |
| cfg_pitch | input | STRIDE_W | Bytes per source line |
| cfg_src_bytes | input | COORD_W | Source width in bytes |
| cfg_src_lines | input | COORD_W | Source height in lines |
| cfg_hstep | input | COORD_W+FRAC_W | Horizontal increment, 12 fraction bits |
| cfg_vstep | input | COORD_W+FRAC_W | Vertical increment, 12 fraction bits |
| cfg_hstart | input | COORD_W+FRAC_W | Horizontal start value |
| cfg_vstart | input | COORD_W+FRAC_W | Vertical start value |
| cfg_fmt | input | 1 | Pixel format, 0 = 16 bpp, 1 = 32 bpp |
| cfg_commit | input | 1 | Request to apply the live set at the next frame command |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Command beat accepted |
| cmd_op | input | 2 | Command operation |
| pix_valid | output | 1 | Result beat valid |
| pix_ready | input | 1 | Result consumer ready |
| pix_x | output | COORD_W | Source column |
| pix_y | output | COORD_W | Source row |
| pix_addr | output | ADDR_W | Fetch byte address |
| color_expand | output | 1 | Working format is below 24 bpp |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit coordinates and 12 fraction bits, which makes a 28-bit accumulator. Source rectangles are kept small, up to a few tens of pixels, against output sizes up to 32. As a result, the last output pixel of nearly every line lands on the clamp boundary. A directed start value near the top of the 28-bit range combined with a modest increment exposes the difference between saturating and wrapping, since a wrapped accumulator would give a small column instead of the clamped one. The 32-bit address width lets random bases wrap the address sum.

// File: rtl/win_scale_pkg.sv
package win_scale_pkg;

  typedef enum logic [1:0] {
    WOP_STEP  = 2'd0,
    WOP_LINE  = 2'd1,
    WOP_FRAME = 2'd2,
    WOP_HOLD  = 2'd3
  } win_op_e;

  typedef enum logic {
    PIX_16B = 1'b0,
    PIX_32B = 1'b1
  } pix_fmt_e;

  // log2 of bytes per pixel
  function automatic logic [1:0] fmt_byte_shift(pix_fmt_e f);
    return (f == PIX_32B) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic fmt_needs_expand(pix_fmt_e f);
    return (f == PIX_16B);
  endfunction

endpackage

// File: rtl/win_cfg_shadow.sv
module win_cfg_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic         commit,
  input  logic         apply_evt,
  output logic [W-1:0] active,
  output logic         applying
);

  logic pending;

  assign applying = apply_evt && (pending || commit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= '0;
      pending <= 1'b0;
    end else if (applying) begin
      active  <= live;
      pending <= 1'b0;
    end else if (commit) begin
      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/win_dda_axis.sv
module win_dda_axis #(
  parameter int COORD_W = 16,
  parameter int FRAC_W  = 12,
  localparam int ACC_W  = COORD_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ACC_W-1:0]   load_val,
  input  logic               step,
  input  logic [ACC_W-1:0]   inc,
  input  logic [COORD_W-1:0] limit,
  output logic [COORD_W-1:0] coord
);

  logic [ACC_W-1:0]   acc;
  logic [ACC_W:0]     sum;
  logic [ACC_W-1:0]   acc_sat;
  logic [COORD_W-1:0] ipart;

  assign sum     = {1'b0, acc} + {1'b0, inc};
  assign acc_sat = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (load) acc <= load_val;
    else if (step) acc <= acc_sat;
  end

  assign ipart = acc[ACC_W-1:FRAC_W];

  always_comb begin
    if (limit == '0)         coord = '0;
    else if (ipart >= limit) coord = limit - COORD_W'(1);
    else                     coord = ipart;
  end

endmodule

// File: rtl/win_addr_calc.sv
module win_addr_calc #(
  parameter int ADDR_W   = 32,
  parameter int COORD_W  = 16,
  parameter int STRIDE_W = 16
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [COORD_W-1:0]  xoff,
  input  logic [COORD_W-1:0]  yoff,
  input  logic [STRIDE_W-1:0] pitch,
  input  logic [COORD_W-1:0]  x,
  input  logic [COORD_W-1:0]  y,
  input  logic [1:0]          byte_shift,
  output logic [ADDR_W-1:0]   addr
);

  logic [ADDR_W-1:0] row;
  logic [ADDR_W-1:0] col_bytes;
  logic [ADDR_W-1:0] row_bytes;

  assign row       = ADDR_W'(yoff) + ADDR_W'(y);
  assign col_bytes = ADDR_W'(x) << byte_shift;
  assign row_bytes = row * ADDR_W'(pitch);
  assign addr      = base + ADDR_W'(xoff) + col_bytes + row_bytes;

endmodule

// File: rtl/win_scale_addr_gen.sv
module win_scale_addr_gen
  import win_scale_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int COORD_W  = 16,
  parameter int FRAC_W   = 12,
  parameter int STRIDE_W = 16,
  localparam int ACC_W   = COORD_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [COORD_W-1:0]  cfg_xoff,
  input  logic [COORD_W-1:0]  cfg_yoff,
  input  logic [STRIDE_W-1:0] cfg_pitch,
  input  logic [COORD_W-1:0]  cfg_src_bytes,
  input  logic [COORD_W-1:0]  cfg_src_lines,
  input  logic [ACC_W-1:0]    cfg_hstep,
  input  logic [ACC_W-1:0]    cfg_vstep,
  input  logic [ACC_W-1:0]    cfg_hstart,
  input  logic [ACC_W-1:0]    cfg_vstart,
  input  logic                cfg_fmt,
  input  logic                cfg_commit,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  output logic                pix_valid,
  input  logic                pix_ready,
  output logic [COORD_W-1:0]  pix_x,
  output logic [COORD_W-1:0]  pix_y,
  output logic [ADDR_W-1:0]   pix_addr,
  output logic                color_expand
);

  localparam int CFG_W = ADDR_W + 4*COORD_W + STRIDE_W + 4*ACC_W + 1;

  // working configuration
  logic [ADDR_W-1:0]   a_base;
  logic [COORD_W-1:0]  a_xoff, a_yoff, a_src_bytes, a_src_lines;
  logic [STRIDE_W-1:0] a_pitch;
  logic [ACC_W-1:0]    a_hstep, a_vstep, a_hstart, a_vstart;
  logic                a_fmt;

  logic [CFG_W-1:0] cfg_live, cfg_work;
  logic             applying;

  logic             accept;
  win_op_e          op;
  logic             frame_evt, line_evt, step_evt;
  logic             first_line;
  logic [1:0]       byte_shift;
  logic [COORD_W-1:0] x_limit, y_limit;
  logic [ACC_W-1:0] h_load_val, v_load_val;

  assign cfg_live = {cfg_base, cfg_xoff, cfg_yoff, cfg_pitch, cfg_src_bytes,
                     cfg_src_lines, cfg_hstep, cfg_vstep, cfg_hstart,
                     cfg_vstart, cfg_fmt};
  assign {a_base, a_xoff, a_yoff, a_pitch, a_src_bytes, a_src_lines,
          a_hstep, a_vstep, a_hstart, a_vstart, a_fmt} = cfg_work;

  // command stream
  assign cmd_ready = !pix_valid || pix_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign op        = win_op_e'(cmd_op);
  assign frame_evt = accept && (op == WOP_FRAME);
  assign line_evt  = accept && (op == WOP_LINE);
  assign step_evt  = accept && (op == WOP_STEP);

  win_cfg_shadow #(.W(CFG_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (cfg_live),
    .commit    (cfg_commit),
    .apply_evt (frame_evt),
    .active    (cfg_work),
    .applying  (applying)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_line <= 1'b1;
      pix_valid  <= 1'b0;
    end else begin
      if (frame_evt)     first_line <= 1'b1;
      else if (line_evt) first_line <= 1'b0;
      if (accept)         pix_valid <= 1'b1;
      else if (pix_ready) pix_valid <= 1'b0;
    end
  end

  // a frame that applies a new set starts from the new start values
  assign h_load_val = applying ? cfg_hstart : a_hstart;
  assign v_load_val = applying ? cfg_vstart : a_vstart;

  assign byte_shift   = fmt_byte_shift(pix_fmt_e'(a_fmt));
  assign color_expand = fmt_needs_expand(pix_fmt_e'(a_fmt));
  assign x_limit      = a_src_bytes >> byte_shift;
  assign y_limit      = a_src_lines;

  win_dda_axis #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) u_h_axis (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_evt || line_evt),
    .load_val (h_load_val),
    .step     (step_evt),
    .inc      (a_hstep),
    .limit    (x_limit),
    .coord    (pix_x)
  );

  win_dda_axis #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) u_v_axis (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_evt),
    .load_val (v_load_val),
    .step     (line_evt && !first_line),
    .inc      (a_vstep),
    .limit    (y_limit),
    .coord    (pix_y)
  );

  win_addr_calc #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .STRIDE_W(STRIDE_W)) u_addr (
    .base       (a_base),
    .xoff       (a_xoff),
    .yoff       (a_yoff),
    .pitch      (a_pitch),
    .x          (pix_x),
    .y          (pix_y),
    .byte_shift (byte_shift),
    .addr       (pix_addr)
  );

endmodule

// File: rtl/win_scale_addr_gen_chk.sv
module win_scale_addr_gen_chk #(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [1:0]         cmd_op,
  input logic               pix_valid,
  input logic               pix_ready,
  input logic [COORD_W-1:0] pix_x,
  input logic [COORD_W-1:0] pix_y,
  input logic [ADDR_W-1:0]  pix_addr,
  input logic               color_expand,
  input logic [COORD_W-1:0] x_limit,
  input logic [COORD_W-1:0] y_limit,
  input logic               frame_evt
);

  // R1: accepted command always produces a beat
  assert_beat_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> pix_valid);

  // R2: stalled result holds and blocks commands
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_addr)));

  assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |-> !cmd_ready);

  // R3: repeat operation leaves the beat unchanged
  assert_hold_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> ($stable(pix_x) && $stable(pix_y) && $stable(pix_addr)));

  // R6: coordinates within the source rectangle
  assert_x_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (x_limit == '0) ? (pix_x == '0) : (pix_x < x_limit));

  assert_y_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (y_limit == '0) ? (pix_y == '0) : (pix_y < y_limit));

  // R10: format changes only right after a frame command
  assert_fmt_at_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_evt) |-> $stable(color_expand));

endmodule

bind win_scale_addr_gen win_scale_addr_gen_chk #(
  .ADDR_W  (ADDR_W),
  .COORD_W (COORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .pix_valid    (pix_valid),
  .pix_ready    (pix_ready),
  .pix_x        (pix_x),
  .pix_y        (pix_y),
  .pix_addr     (pix_addr),
  .color_expand (color_expand),
  .x_limit      (x_limit),
  .y_limit      (y_limit),
  .frame_evt    (frame_evt)
);

// File: tb/win_scale_addr_gen_bench.sv
module win_scale_addr_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam longint ACC_MAX = (64'd1 << 28) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_xoff = '0, cfg_yoff = '0, cfg_pitch = '0;
  logic [15:0] cfg_src_bytes = '0, cfg_src_lines = '0;
  logic [27:0] cfg_hstep = '0, cfg_vstep = '0, cfg_hstart = '0, cfg_vstart = '0;
  logic        cfg_fmt = 1'b0, cfg_commit = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        pix_ready = 1'b1;
  logic        cmd_ready, pix_valid, color_expand;
  logic [15:0] pix_x, pix_y;
  logic [31:0] pix_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  longint m_h, m_v;
  bit     m_first, m_pend;
  longint a_base, a_xoff, a_yoff, a_pitch, a_sb, a_sl, a_hs, a_vs, a_h0, a_v0;
  bit     a_fmt;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_scale_addr_gen u_win_scale_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_xoff(cfg_xoff),
    .cfg_yoff(cfg_yoff), .cfg_pitch(cfg_pitch), .cfg_src_bytes(cfg_src_bytes),
    .cfg_src_lines(cfg_src_lines), .cfg_hstep(cfg_hstep), .cfg_vstep(cfg_vstep),
    .cfg_hstart(cfg_hstart), .cfg_vstart(cfg_vstart), .cfg_fmt(cfg_fmt),
    .cfg_commit(cfg_commit), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_x(pix_x), .pix_y(pix_y), .pix_addr(pix_addr), .color_expand(color_expand)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int shf();
    return a_fmt ? 2 : 1;
  endfunction

  function automatic longint clampc(longint ip, longint lim);
    if (lim == 0) return 0;
    if (ip >= lim) return lim - 1;
    return ip;
  endfunction

  function automatic longint exp_x();
    return clampc(m_h >> 12, a_sb >> shf());
  endfunction

  function automatic longint exp_y();
    return clampc(m_v >> 12, a_sl);
  endfunction

  function automatic longint exp_addr();
    longint s;
    s = a_base + a_xoff + (exp_x() << shf()) + (a_yoff + exp_y()) * a_pitch;
    return s & 64'hFFFF_FFFF;
  endfunction

  function automatic longint sat(longint v);
    return (v > ACC_MAX) ? ACC_MAX : v;
  endfunction

  task automatic model_cmd(input logic [1:0] op, input bit commit);
    bit app;
    app = (op == 2'd2) && (m_pend || commit);
    if (app) begin
      a_base = cfg_base; a_xoff = cfg_xoff; a_yoff = cfg_yoff; a_pitch = cfg_pitch;
      a_sb = cfg_src_bytes; a_sl = cfg_src_lines; a_hs = cfg_hstep; a_vs = cfg_vstep;
      a_h0 = cfg_hstart; a_v0 = cfg_vstart; a_fmt = cfg_fmt;
      m_pend = 0;
    end else if (commit) m_pend = 1;
    case (op)
      2'd0: m_h = sat(m_h + a_hs);
      2'd1: begin
        m_h = a_h0;
        if (!m_first) m_v = sat(m_v + a_vs);
        m_first = 0;
      end
      2'd2: begin m_h = a_h0; m_v = a_v0; m_first = 1; end
      default: ;
    endcase
  endtask

  task automatic check_beat(input string req);
    chk({req, " valid"}, pix_valid, 1);
    chk({req, " x"}, pix_x, exp_x());
    chk({req, " y"}, pix_y, exp_y());
    chk({req, " addr"}, pix_addr, exp_addr());
    chk({req, " expand"}, color_expand, !a_fmt);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic issue(input logic [1:0] op, input bit commit, input string req);
    cmd_valid = 1'b1; cmd_op = op; cfg_commit = commit;
    @(posedge clk);
    #1 cmd_valid = 1'b0; cfg_commit = 1'b0;
    model_cmd(op, commit);
    @(negedge clk);
    check_beat(req);
  endtask

  task automatic commit_pulse();
    cfg_commit = 1'b1;
    @(posedge clk);
    #1 cfg_commit = 1'b0;
    m_pend = 1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input int wpx, input int hl, input int outw, input int outh,
                         input bit fmt, input bit rnd_start);
    int d;
    cfg_fmt = fmt;
    cfg_src_bytes = 16'(wpx << (fmt ? 2 : 1));
    cfg_src_lines = 16'(hl);
    d = (outw - 1 > 1) ? outw - 1 : 1;
    cfg_hstep = 28'((wpx * 4096) / d);
    d = (outh - 1 > 1) ? outh - 1 : 1;
    cfg_vstep = 28'((hl * 4096) / d);
    cfg_hstart = rnd_start ? 28'($urandom % 8192) : '0;
    cfg_vstart = rnd_start ? 28'($urandom % 8192) : '0;
    cfg_base = $urandom;
    cfg_xoff = 16'($urandom % 256);
    cfg_yoff = 16'($urandom % 64);
    cfg_pitch = 16'((wpx << (fmt ? 2 : 1)) + ($urandom % 64));
  endtask

  task automatic run_frame(input int outw, input int outh);
    issue(2'd2, 1'b0, "R10");
    for (int l = 0; l < outh; l++) begin
      issue(2'd1, 1'b0, "R5");
      for (int p = 1; p < outw; p++) begin
        issue(2'd0, 1'b0, "R4");
        if ($urandom % 16 == 0) issue(2'd3, 1'b0, "R3");
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_h = 0; m_v = 0; m_first = 1; m_pend = 0;
    a_base = 0; a_xoff = 0; a_yoff = 0; a_pitch = 0; a_sb = 0; a_sl = 0;
    a_hs = 0; a_vs = 0; a_h0 = 0; a_v0 = 0; a_fmt = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 pix_valid", pix_valid, 0);
    chk("R11 cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 pix_x", pix_x, 0);
    chk("R11 pix_addr", pix_addr, 0);

    // R10: live values without commit are not used
    set_cfg(20, 10, 30, 15, 1'b1, 1'b0);
    issue(2'd2, 1'b0, "R10 no commit");
    chk("R10 old base kept", pix_addr, 0);
    commit_pulse();
    issue(2'd1, 1'b0, "R10 line does not apply");
    issue(2'd2, 1'b0, "R10 frame applies");
    chk("R9 32bpp expand", color_expand, 0);
    run_frame(30, 15);

    // R10 commit together with the frame command; R9 16 bpp
    set_cfg(12, 6, 25, 9, 1'b0, 1'b1);
    issue(2'd2, 1'b1, "R10 same cycle");
    chk("R9 16bpp expand", color_expand, 1);
    run_frame(25, 9);

    // R6 zero-size source
    set_cfg(0, 0, 8, 4, 1'b0, 1'b1);
    cfg_hstep = 28'h3000; cfg_vstep = 28'h2000;
    issue(2'd2, 1'b1, "R6 zero size");
    issue(2'd1, 1'b0, "R6 zero size");
    issue(2'd0, 1'b0, "R6 zero size");
    chk("R6 zero width x", pix_x, 0);

    // R7 saturation instead of wrap
    set_cfg(40, 4, 40, 4, 1'b0, 1'b0);
    cfg_hstart = 28'h0FFF_0000; cfg_hstep = 28'h0002_0000;
    issue(2'd2, 1'b1, "R7");
    issue(2'd0, 1'b0, "R7 saturate");
    chk("R7 clamped not wrapped", pix_x, 39);
    issue(2'd0, 1'b0, "R7 stays");

    // R8 address wrap with high base
    set_cfg(8, 8, 8, 8, 1'b1, 1'b0);
    cfg_base = 32'hFFFF_FFF0;
    issue(2'd2, 1'b1, "R8 wrap");
    run_frame(8, 8);

    // R2 / R1 back-pressure
    pix_ready = 1'b0;
    issue(2'd0, 1'b0, "R2 first beat");
    cmd_valid = 1'b1; cmd_op = 2'd0;
    #1 chk("R2 cmd_ready low", cmd_ready, 0);
    @(posedge clk);
    @(negedge clk);
    check_beat("R2 held");
    @(posedge clk);
    @(negedge clk);
    check_beat("R2 still held");
    cmd_valid = 1'b0;
    pix_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 valid drops", pix_valid, 0);
    chk("R1 ready back", cmd_ready, 1);

    // random configurations
    for (int c = 0; c < 12; c++) begin
      int wpx, hl, ow, oh;
      wpx = 1 + $urandom % 24; hl = 1 + $urandom % 16;
      ow = 1 + $urandom % 32; oh = 1 + $urandom % 12;
      set_cfg(wpx, hl, ow, oh, 1'($urandom % 2), ($urandom % 2) == 1);
      commit_pulse();
      run_frame(ow, oh);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule